// File: doc/BRIEF.md
# Rotating Submodule Gate Allocator

The block drives the eight half-bridge submodules of one phase leg in a five-level modular multilevel converter: four submodules in the upper arm and four in the lower arm. From a signed output level it derives how many submodules each arm must insert. The two counts always add up to four. It turns each count into four ranked gate patterns, where pattern k is active when the count is at least k. The patterns are routed to physical submodules through a rotating map, and each submodule receives a complementary pair of top-switch and bottom-switch commands separated by a programmable dead time.

Capacitor balancing is open loop. A strobe at every fundamental-cycle boundary advances a rotation index, and the pattern-to-submodule map shifts by one place. Over four cycles every submodule takes every pattern once, so its net charge evens out. No voltage measurement or sorting is involved.

Top module: `mmc_arm_rotator`

## Requirements
- R1: The level input is a signed 4-bit number. Values above +2 are treated as +2 and values below -2 as -2. The upper arm then inserts 2 - level submodules and the lower arm inserts 2 + level submodules.
- R2: Bit s (0..3) of each arm's output vectors is submodule s+1. With rotation index r, pattern Gk (k = 1..4) drives submodule ((k-1+r) mod 4)+1, and Gk is active when the arm count is at least k. So submodule s+1 is inserted when the count is greater than ((s - r) mod 4).
- R3: A strobe sampled high on a clock edge advances the index by one, from 3 back to 0. The new map is used from the following edge onward. Without a strobe, the map never changes.
- R4: With zero dead time, a level sampled at a clock edge is visible on the outputs straight after that edge.
- R5: The top and bottom commands of a submodule are never both high.
- R6: When a submodule's command changes, both of its switches are off for exactly dead_time clock cycles, and then the new switch turns on. A dead time of 0 switches directly.
- R7: If the command reverses while the dead window is still running, the window restarts at full length with the reversed command.
- R8: During reset the rotation index is 0, every bottom switch is on and every top switch is off.
- R9: When the level is held constant and four equal fundamental periods are strobed, each submodule of an arm is inserted for the same number of cycles.
- R10: When no submodule of an arm is inside a dead window, the number of top switches on in that arm equals the count required by the previous cycle's level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level | input | 4 | Signed requested output level |
| cycle_strobe | input | 1 | One-cycle pulse at a fundamental-cycle boundary |
| dead_time | input | 6 | Dead time in clock cycles |
| up_top | output | 4 | Upper-arm top switches (insert) |
| up_bot | output | 4 | Upper-arm bottom switches (bypass) |
| lo_top | output | 4 | Lower-arm top switches (insert) |
| lo_bot | output | 4 | Lower-arm bottom switches (bypass) |

## Verification
Two functions can act in the same cycle. A level change that hands a pattern to a different submodule can coincide with a rotation step that moves the patterns between submodules. A level reversal can also land while a dead window is still counting down. The bench provokes the first case by strobing while the level is nonzero, and the second by reversing the level two cycles into a four-cycle dead window. A behavioural model advances every clock and judges the outcome. It predicts the exact dead-sample count (six) and the submodule that ends up inserted after each rotation.

// File: rtl/mmc_arm_rotator.sv
`timescale 1ns/1ps
module mmc_arm_rotator #(
  parameter int NSM = 4,
  parameter int DTW = 6,
  localparam int LW = $clog2(NSM + 1) + 1,
  localparam int RW = (NSM > 1) ? $clog2(NSM) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [LW-1:0] level,
  input  logic                 cycle_strobe,
  input  logic [DTW-1:0]       dead_time,
  output logic [NSM-1:0]       up_top,
  output logic [NSM-1:0]       up_bot,
  output logic [NSM-1:0]       lo_top,
  output logic [NSM-1:0]       lo_bot
);
  localparam int HALF = NSM / 2;
  localparam logic signed [LW-1:0] LMAX = LW'(HALF);
  localparam logic signed [LW-1:0] LMIN = -LMAX;

  logic [RW-1:0]         rot;
  logic signed [LW-1:0]  lvl_c;
  logic [LW-1:0]         n_up, n_lo;
  logic [2*NSM-1:0]      want, state;
  logic [DTW-1:0]        hold [2*NSM];

  assign lvl_c = (level > LMAX) ? LMAX : (level < LMIN) ? LMIN : level;
  assign n_up  = LW'(HALF - int'(lvl_c));
  assign n_lo  = LW'(HALF + int'(lvl_c));

  always_comb
    for (int s = 0; s < NSM; s++) begin
      want[s]       = int'(n_up) > ((s + NSM - int'(rot)) % NSM);
      want[NSM + s] = int'(n_lo) > ((s + NSM - int'(rot)) % NSM);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            rot <= '0;
    else if (cycle_strobe) rot <= (int'(rot) == NSM - 1) ? '0 : rot + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= '0;
      for (int i = 0; i < 2*NSM; i++) hold[i] <= '0;
    end else begin
      for (int i = 0; i < 2*NSM; i++)
        if (want[i] != state[i]) begin
          state[i] <= want[i];
          hold[i]  <= dead_time;
        end else if (hold[i] != '0) begin
          hold[i]  <= hold[i] - 1'b1;
        end
    end

  always_comb
    for (int s = 0; s < NSM; s++) begin
      up_top[s] =  state[s]       && (hold[s] == '0);
      up_bot[s] = !state[s]       && (hold[s] == '0);
      lo_top[s] =  state[NSM + s] && (hold[NSM + s] == '0);
      lo_bot[s] = !state[NSM + s] && (hold[NSM + s] == '0);
    end
endmodule

module mmc_arm_rotator_sva #(
  parameter int NSM = 4,
  parameter int DTW = 6,
  localparam int LW = $clog2(NSM + 1) + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [LW-1:0] level,
  input logic                 cycle_strobe,
  input logic [DTW-1:0]       dead_time,
  input logic [NSM-1:0]       up_top,
  input logic [NSM-1:0]       up_bot,
  input logic [NSM-1:0]       lo_top,
  input logic [NSM-1:0]       lo_bot
);
  localparam logic [NSM-1:0] ALL = '1;
  logic pv, pv2;
  logic was_low = 1'b0;

  function automatic int need(input int l, input bit upper);
    int c;
    c = (l > NSM/2) ? NSM/2 : (l < -(NSM/2)) ? -(NSM/2) : l;
    return upper ? NSM/2 - c : NSM/2 + c;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin pv <= 1'b0; pv2 <= 1'b0; end
    else        begin pv <= 1'b1; pv2 <= pv;   end

  always_ff @(posedge clk) was_low <= !rst_n;

  assert_reset_bypass_R8: assert property (@(posedge clk)
    (!rst_n && was_low) |-> (up_bot == ALL && lo_bot == ALL && up_top == '0 && lo_top == '0));

  assert_no_shoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_top & up_bot) == '0) && ((lo_top & lo_bot) == '0));

  assert_arm_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && (up_top | up_bot) == ALL) |-> ($countones(up_top) == need(int'($past(level)), 1'b1)));

  assert_arm_count_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && (lo_top | lo_bot) == ALL) |-> ($countones(lo_top) == need(int'($past(level)), 1'b0)));

  assert_map_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pv2 && $past(level) == $past(level, 2) && !$past(cycle_strobe, 2) &&
     (up_top | up_bot) == ALL && $past((up_top | up_bot) == ALL)) |-> $stable(up_top));

  for (genvar i = 0; i < NSM; i++) begin : g_gap
    assert_gap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && $past(dead_time) != '0 && $past(up_top[i])) |-> !up_bot[i]);
    assert_gap_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pv && $past(dead_time) != '0 && $past(lo_bot[i])) |-> !lo_top[i]);
  end
endmodule

bind mmc_arm_rotator mmc_arm_rotator_sva #(.NSM(NSM), .DTW(DTW)) u_sva (.*);

// File: tb/mmc_arm_rotator_bench.sv
`timescale 1ns/1ps
module mmc_arm_rotator_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [3:0] level = '0;
  logic cycle_strobe = 1'b0;
  logic [5:0] dead_time = '0;
  logic [3:0] up_top, up_bot, lo_top, lo_bot;
  int errors = 0, checks = 0, ovl = 0;
  bit done = 1'b0;

  mmc_arm_rotator u_mmc_arm_rotator (.*);

  always #2 clk = ~clk;

  int m_rot = 0;
  bit m_state [8] = '{default: 1'b0};
  int m_hold  [8] = '{default: 0};

  function automatic int clampl(input int l);
    return (l > 2) ? 2 : (l < -2) ? -2 : l;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rot = 0;
      for (int s = 0; s < 8; s++) begin m_state[s] = 0; m_hold[s] = 0; end
    end else begin
      int nu, nl, pat;
      bit w;
      nu = 2 - clampl(int'(level));
      nl = 2 + clampl(int'(level));
      for (int s = 0; s < 8; s++) begin
        pat = ((s % 4) - m_rot + 4) % 4;
        w = ((s < 4) ? nu : nl) > pat;
        if (w != m_state[s]) begin m_state[s] = w; m_hold[s] = int'(dead_time); end
        else if (m_hold[s] > 0) m_hold[s]--;
      end
      if (cycle_strobe) m_rot = (m_rot + 1) % 4;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R2 R3 R4 R6 R7: per-cycle comparison against the model
  always @(negedge clk) begin
    logic [15:0] e;
    for (int s = 0; s < 4; s++) begin
      e[12+s] =  m_state[s]   && m_hold[s] == 0;
      e[8+s]  = !m_state[s]   && m_hold[s] == 0;
      e[4+s]  =  m_state[4+s] && m_hold[4+s] == 0;
      e[s]    = !m_state[4+s] && m_hold[4+s] == 0;
    end
    if (!done) chk("R2 R3 R4 R6 R7 model", {up_top, up_bot, lo_top, lo_bot}, e);
    if ((up_top & up_bot) != 0 || (lo_top & lo_bot) != 0) ovl++;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL R4 watchdog actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int cu [4];
    int cl [4];
    tick(3);
    chk("R8 reset up_bot", up_bot, 4'hF);
    chk("R8 reset lo_bot", lo_bot, 4'hF);
    chk("R8 reset tops", {up_top, lo_top}, 8'h00);
    rst_n = 1'b1;
    tick(1);
    chk("R2 level0 rot0 up", up_top, 4'b0011);
    chk("R2 level0 rot0 lo", lo_top, 4'b0011);

    level = 2;  tick(1);
    chk("R1 R4 +2 up", up_top, 4'b0000);
    chk("R1 R4 +2 lo", lo_top, 4'b1111);
    level = 7;  tick(1);
    chk("R1 clamp +7 up", up_top, 4'b0000);
    chk("R1 clamp +7 lo", lo_top, 4'b1111);
    level = -2; tick(1);
    chk("R1 -2 up", up_top, 4'b1111);
    chk("R1 -2 lo", lo_top, 4'b0000);
    level = -8; tick(1);
    chk("R1 clamp -8 up", up_top, 4'b1111);
    chk("R1 clamp -8 lo", lo_top, 4'b0000);
    level = 1;  tick(1);
    chk("R2 +1 rot0 up", up_top, 4'b0001);
    chk("R2 +1 rot0 lo", lo_top, 4'b0111);

    cycle_strobe = 1; tick(1); cycle_strobe = 0;
    chk("R3 map not yet moved", up_top, 4'b0001);
    tick(1);
    chk("R3 rot1 up", up_top, 4'b0010);
    chk("R3 rot1 lo", lo_top, 4'b1110);
    tick(5);
    chk("R3 steady without strobe", up_top, 4'b0010);
    repeat (3) begin cycle_strobe = 1; tick(1); cycle_strobe = 0; tick(1); end
    chk("R3 wrap up", up_top, 4'b0001);
    chk("R3 wrap lo", lo_top, 4'b0111);

    cycle_strobe = 1; tick(1); cycle_strobe = 0; tick(1);
    for (int s = 0; s < 4; s++) begin cu[s] = 0; cl[s] = 0; end
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 10; c++) begin
        for (int s = 0; s < 4; s++) begin cu[s] += int'(up_top[s]); cl[s] += int'(lo_top[s]); end
        cycle_strobe = (c == 8);
        tick(1);
      end
    cycle_strobe = 0;
    for (int s = 0; s < 4; s++) begin
      chk("R9 balance up", cu[s], 10);
      chk("R9 balance lo", cl[s], 30);
    end

    dead_time = 3; level = -1; n = 0;
    repeat (8) begin tick(1); if ((up_top | up_bot) != 4'hF) n++; end
    chk("R6 dead cycles 3", n, 3);
    chk("R10 up count -1", $countones(up_top), 3);
    chk("R10 lo count -1", $countones(lo_top), 1);

    dead_time = 0; level = 1; n = 0;
    repeat (4) begin tick(1); if ((up_top | up_bot) != 4'hF) n++; end
    chk("R6 zero dead time", n, 0);
    chk("R10 up count +1", $countones(up_top), 1);

    dead_time = 4; level = -1; n = 0;
    repeat (2) begin tick(1); if ((up_top | up_bot) != 4'hF) n++; end
    level = 1;
    repeat (10) begin tick(1); if ((up_top | up_bot) != 4'hF) n++; end
    chk("R7 restarted window", n, 6);
    chk("R7 final up count", $countones(up_top), 1);

    chk("R5 no overlap seen", ovl, 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule